// File: doc/BRIEF.md
# Dual-Synthesizer Serial Control Word Loader

This block is the receive side of a three-wire serial control port (data, clock, enable) that programs two frequency synthesizers. Each synthesizer has a reference-divider register and a main-divider register, so four 22-bit registers are held in total. A host lowers enable and clocks in one 22-bit word, most significant bit first. It then raises enable. On that rising edge the block reads the two lowest bits of the word as an address and stores the word in the addressed register.

All three serial lines are asynchronous to the system clock. Each passes through two flip-flop stages, and edges are found on the synchronized copies. For the two reference registers, the block also splits out a 5-bit mode field and a 15-bit divide ratio. A reference word whose ratio is below 3 is refused: the register keeps its old value and a sticky error flag is set. A frame of any length other than 22 bits is dropped and a one-cycle frame-error pulse is raised.

Top module: `synth_word_loader`

## Requirements
- R1: A frame is the bits sampled on rising edges of the synchronized serial clock while enable is low. The first bit received lands in bit 21 and the last in bit 0. The word is committed on the rising edge of the synchronized enable.
- R2: Word bits [1:0] choose the destination: 00 is the synthesizer-2 reference register (`ref2_word`), 01 is the synthesizer-2 main register (`main2_word`), 10 is the synthesizer-1 reference register (`ref1_word`), and 11 is the synthesizer-1 main register (`main1_word`).
- R3: For each reference register, the mode output is stored bits [21:17] and the ratio output is stored bits [16:2].
- R4: A reference word (bit 0 = 0) whose ratio field is 0, 1 or 2 leaves its register unchanged and sets `ratio_err`. The flag stays set until reset.
- R5: Main-register words (bit 0 = 1) are stored whatever their upper bits hold.
- R6: A frame of fewer or more than 22 bits leaves all registers unchanged and pulses `frame_err` high for exactly one cycle.
- R7: Serial clock edges while enable is high neither shift data nor count toward the next frame.
- R8: After reset all four registers are zero, both valid flags are low and both error flags are low.
- R9: `ref1_valid` / `ref2_valid` rise on the first accepted load of that reference register and stay high until reset. While high, the matching ratio is at least 3.
- R10: `upd[i]` pulses for one cycle in the cycle register i (index = select code of R2) is written. At most one bit is high at a time, and no register changes without its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Serial enable, low during entry, asynchronous |
| ref2_word | output | 22 | Synthesizer-2 reference register |
| main2_word | output | 22 | Synthesizer-2 main register |
| ref1_word | output | 22 | Synthesizer-1 reference register |
| main1_word | output | 22 | Synthesizer-1 main register |
| upd | output | 4 | Per-register write strobes, indexed by select code |
| ref1_mode | output | 5 | Synthesizer-1 reference mode field |
| ref1_ratio | output | 15 | Synthesizer-1 reference divide ratio |
| ref1_valid | output | 1 | Synthesizer-1 reference register holds a legal word |
| ref2_mode | output | 5 | Synthesizer-2 reference mode field |
| ref2_ratio | output | 15 | Synthesizer-2 reference divide ratio |
| ref2_valid | output | 1 | Synthesizer-2 reference register holds a legal word |
| ratio_err | output | 1 | Sticky flag: a reference ratio below 3 was refused |
| frame_err | output | 1 | One-cycle pulse: a frame of wrong length was dropped |

## Verification
The hardest cases to reach from the ports are frames that carry a well-formed word but a wrong bit count. One is a 23-bit frame whose last 22 bits would be valid on their own. The other is serial clock activity while enable is high, which must not leave a stale count behind for the next frame. The bench drives these directly with a bit-level serial task. For the ignored-clock case, a full legal frame follows straight after, and its clean acceptance shows that the count was really cleared. Every serial level is held for several system clocks so that each edge clears the synchronizers before the next one arrives.

// File: rtl/synth_word_loader.sv
module synth_word_loader #(
  parameter int WORD_W    = 22,
  parameter int MODE_W    = 5,
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                ser_data,
  input  logic                ser_en,
  output logic [WORD_W-1:0]   ref2_word,
  output logic [WORD_W-1:0]   main2_word,
  output logic [WORD_W-1:0]   ref1_word,
  output logic [WORD_W-1:0]   main1_word,
  output logic [3:0]          upd,
  output logic [MODE_W-1:0]   ref1_mode,
  output logic [RATIO_W-1:0]  ref1_ratio,
  output logic                ref1_valid,
  output logic [MODE_W-1:0]   ref2_mode,
  output logic [RATIO_W-1:0]  ref2_ratio,
  output logic                ref2_valid,
  output logic                ratio_err,
  output logic                frame_err
);
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam int R_LO   = 2;
  localparam int R_HI   = R_LO + RATIO_W - 1;
  localparam int M_LO   = R_HI + 1;
  localparam int M_HI   = M_LO + MODE_W - 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic [2:0] sclk_p, en_p;
  logic [1:0] sdat_p;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] regs [4];
  logic [1:0] valid_q;

  wire en_s     = en_p[1];
  wire clk_rise = sclk_p[1] & ~sclk_p[2];
  wire en_rise  = en_p[1] & ~en_p[2];
  wire [1:0] sel = shreg[1:0];
  wire bad_ratio = shreg[R_HI:R_LO] < RATIO_W'(MIN_RATIO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      sdat_p <= '0;
      en_p   <= '1;
    end else begin
      sclk_p <= {sclk_p[1:0], ser_clk};
      sdat_p <= {sdat_p[0], ser_data};
      en_p   <= {en_p[1:0], ser_en};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      upd       <= '0;
      frame_err <= 1'b0;
      ratio_err <= 1'b0;
      valid_q   <= '0;
      for (int i = 0; i < 4; i++) regs[i] <= '0;
    end else begin
      upd       <= '0;
      frame_err <= 1'b0;
      if (en_s) begin
        cnt <= '0;
      end else if (clk_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdat_p[1]};
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end
      if (en_rise) begin
        if (cnt != FULL) begin
          frame_err <= 1'b1;
        end else if (!sel[0] && bad_ratio) begin
          ratio_err <= 1'b1;
        end else begin
          regs[sel] <= shreg;
          upd[sel]  <= 1'b1;
          if (!sel[0]) valid_q[sel[1]] <= 1'b1;
        end
      end
    end
  end

  assign ref2_word  = regs[0];
  assign main2_word = regs[1];
  assign ref1_word  = regs[2];
  assign main1_word = regs[3];
  assign ref2_valid = valid_q[0];
  assign ref1_valid = valid_q[1];
  assign ref1_mode  = ref1_word[M_HI:M_LO];
  assign ref1_ratio = ref1_word[R_HI:R_LO];
  assign ref2_mode  = ref2_word[M_HI:M_LO];
  assign ref2_ratio = ref2_word[R_HI:R_LO];
endmodule

// File: rtl/synth_word_loader_chk.sv
module synth_word_loader_chk #(
  parameter int WORD_W    = 22,
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WORD_W-1:0]  ref2_word,
  input logic [WORD_W-1:0]  main2_word,
  input logic [WORD_W-1:0]  ref1_word,
  input logic [WORD_W-1:0]  main1_word,
  input logic [3:0]         upd,
  input logic [RATIO_W-1:0] ref1_ratio,
  input logic               ref1_valid,
  input logic [RATIO_W-1:0] ref2_ratio,
  input logic               ref2_valid,
  input logic               ratio_err,
  input logic               frame_err
);
  a_r10_upd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd));
  a_r10_ref2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[0] |-> $stable(ref2_word));
  a_r10_main2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[1] |-> $stable(main2_word));
  a_r10_ref1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[2] |-> $stable(ref1_word));
  a_r10_main1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[3] |-> $stable(main1_word));
  a_r10_upd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (upd != 4'd0) |=> (upd == 4'd0));
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |=> ratio_err);
  a_r6_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  a_r6_no_write_on_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (upd == 4'd0));
  a_r9_valid1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ref1_valid |=> ref1_valid);
  a_r9_valid2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ref2_valid |=> ref2_valid);
  a_r9_valid1_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ref1_valid |-> (ref1_ratio >= RATIO_W'(MIN_RATIO)));
  a_r9_valid2_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ref2_valid |-> (ref2_ratio >= RATIO_W'(MIN_RATIO)));
endmodule

bind synth_word_loader synth_word_loader_chk #(
  .WORD_W(WORD_W), .RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ref2_word(ref2_word), .main2_word(main2_word),
  .ref1_word(ref1_word), .main1_word(main1_word),
  .upd(upd), .ref1_ratio(ref1_ratio), .ref1_valid(ref1_valid),
  .ref2_ratio(ref2_ratio), .ref2_valid(ref2_valid),
  .ratio_err(ratio_err), .frame_err(frame_err)
);

// File: tb/synth_word_loader_bench.sv
module synth_word_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b1;
  logic [21:0] ref2_word, main2_word, ref1_word, main1_word;
  logic [3:0]  upd;
  logic [4:0]  ref1_mode, ref2_mode;
  logic [14:0] ref1_ratio, ref2_ratio;
  logic ref1_valid, ref2_valid, ratio_err, frame_err;

  always #10 clk = ~clk;

  synth_word_loader u_synth_word_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .ref2_word(ref2_word), .main2_word(main2_word), .ref1_word(ref1_word), .main1_word(main1_word),
    .upd(upd), .ref1_mode(ref1_mode), .ref1_ratio(ref1_ratio), .ref1_valid(ref1_valid),
    .ref2_mode(ref2_mode), .ref2_ratio(ref2_ratio), .ref2_valid(ref2_valid),
    .ratio_err(ratio_err), .frame_err(frame_err)
  );

  int checks = 0, errors = 0;
  int upd_cnt [4];
  int ferr_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) upd_cnt[i] <= 0;
      ferr_cnt <= 0;
    end else begin
      for (int i = 0; i < 4; i++) if (upd[i]) upd_cnt[i] <= upd_cnt[i] + 1;
      if (frame_err) ferr_cnt <= ferr_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int n);
    ser_en = 1'b0;
    hold(4);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      hold(4);
      ser_clk = 1'b1;
      hold(4);
      ser_clk = 1'b0;
    end
    hold(4);
    ser_en = 1'b1;
    hold(8);
  endtask

  // bit 22 = expected to be accepted
  localparam logic [22:0] VEC [8] = '{
    {1'b1, 5'h15, 15'd3,     2'b10},
    {1'b1, 22'h12345F},
    {1'b1, 5'h00, 15'h7FFF,  2'b00},
    {1'b1, 22'h3C0F01},
    {1'b0, 5'h1F, 15'd2,     2'b10},
    {1'b0, 5'h0A, 15'd0,     2'b00},
    {1'b1, 5'h01, 15'd4,     2'b10},
    {1'b1, 5'h00, 15'd1,     2'b01}
  };

  logic [21:0] model [4];
  logic exp_rerr;

  task automatic check_regs(input string tag);
    chk(ref2_word  == model[0], {tag, " R2 ref2_word"},  32'(ref2_word),  32'(model[0]));
    chk(main2_word == model[1], {tag, " R2 main2_word"}, 32'(main2_word), 32'(model[1]));
    chk(ref1_word  == model[2], {tag, " R2 ref1_word"},  32'(ref1_word),  32'(model[2]));
    chk(main1_word == model[3], {tag, " R2 main1_word"}, 32'(main1_word), 32'(model[3]));
  endtask

  int snap [4];
  int fsnap;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    exp_rerr = 1'b0;
    hold(3);
    // R8 reset state
    check_regs("R8 reset");
    chk(!ref1_valid && !ref2_valid, "R8 valid low", {ref1_valid, ref2_valid}, 0);
    chk(!ratio_err && !frame_err, "R8 errors low", {ratio_err, frame_err}, 0);
    rst_n = 1'b1;
    hold(4);
    chk(ferr_cnt == 0, "R8 no spurious frame_err", ferr_cnt, 0);

    for (int v = 0; v < 8; v++) begin
      for (int i = 0; i < 4; i++) snap[i] = upd_cnt[i];
      fsnap = ferr_cnt;
      send(32'(VEC[v][21:0]), 22);
      if (VEC[v][22]) model[VEC[v][1:0]] = VEC[v][21:0];
      else exp_rerr = 1'b1;
      check_regs($sformatf("R1 vec%0d", v));
      for (int i = 0; i < 4; i++) begin
        int exp_d;
        exp_d = (VEC[v][22] && VEC[v][1:0] == 2'(i)) ? 1 : 0;
        chk(upd_cnt[i] - snap[i] == exp_d, $sformatf("R10 vec%0d strobe%0d", v, i),
            upd_cnt[i] - snap[i], exp_d);
      end
      chk(ratio_err == exp_rerr, $sformatf("R4 vec%0d ratio_err", v), ratio_err, exp_rerr);
      chk(ferr_cnt == fsnap, $sformatf("R6 vec%0d no frame_err", v), ferr_cnt, fsnap);
      if (v == 2) begin
        chk(ref2_ratio == 15'h7FFF, "R3 ref2_ratio max", ref2_ratio, 32'h7FFF);
        chk(ref2_mode == 5'h00, "R3 ref2_mode", ref2_mode, 0);
        chk(ref2_valid, "R9 ref2_valid set", ref2_valid, 1);
      end
      if (v == 0) begin
        chk(ref1_valid && !ref2_valid, "R9 only ref1_valid", {ref1_valid, ref2_valid}, 2);
        chk(ref1_ratio == 15'd3, "R4 ratio 3 accepted", ref1_ratio, 3);
      end
      if (v == 6) begin
        chk(ref1_mode == 5'h01, "R3 ref1_mode", ref1_mode, 1);
        chk(ref1_ratio == 15'd4, "R3 ref1_ratio", ref1_ratio, 4);
      end
      if (v == 7) chk(main2_word[16:2] == 15'd1, "R5 main low field stored", main2_word[16:2], 1);
    end

    // R6 short frame
    fsnap = ferr_cnt;
    send(32'({5'h03, 15'd9, 2'b11} >> 1), 21);
    check_regs("R6 short");
    chk(ferr_cnt == fsnap + 1, "R6 short frame_err pulse", ferr_cnt - fsnap, 1);

    // R6 long frame whose last 22 bits would be legal
    fsnap = ferr_cnt;
    send({9'd0, 1'b1, 5'h02, 15'd50, 2'b10}, 23);
    check_regs("R6 long");
    chk(ferr_cnt == fsnap + 1, "R6 long frame_err pulse", ferr_cnt - fsnap, 1);

    // R7 clocks while enable high are ignored
    fsnap = ferr_cnt;
    for (int k = 0; k < 5; k++) begin
      ser_data = 1'b1; hold(4); ser_clk = 1'b1; hold(4); ser_clk = 1'b0;
    end
    hold(8);
    check_regs("R7 idle clocks");
    chk(ferr_cnt == fsnap, "R7 no frame_err from idle clocks", ferr_cnt - fsnap, 0);
    send({10'd0, 5'h07, 15'd100, 2'b00}, 22);
    model[0] = {5'h07, 15'd100, 2'b00};
    check_regs("R7 frame after idle clocks");
    chk(ref2_ratio == 15'd100, "R7 ref2_ratio", ref2_ratio, 100);
    chk(ferr_cnt == fsnap, "R7 no frame_err", ferr_cnt - fsnap, 0);

    // R4 reset is the only thing that clears ratio_err
    chk(ratio_err, "R4 still set", ratio_err, 1);
    rst_n = 1'b0;
    hold(2);
    for (int i = 0; i < 4; i++) model[i] = '0;
    check_regs("R8 second reset");
    chk(!ratio_err, "R4 cleared by reset", ratio_err, 0);
    chk(!ref1_valid && !ref2_valid, "R9 valid cleared", {ref1_valid, ref2_valid}, 0);
    rst_n = 1'b1;
    hold(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule